// File: doc/BRIEF.md
# Serial Converter Poll-and-Read Master

This block is the host side of a three-wire link to a serial converter that reports its own readiness. While enabled, it drops the active-low select line with the serial clock parked high. It then reads the data line. High means the converter is still busy. Low means a result is waiting. Busy polls repeat after a fixed gap with the select line high.

Once a poll finds data ready, the block clocks in a 16-bit word, most significant bit first. It presents the word with a single-cycle strobe. It then triggers the converter's next conversion by one of two methods, chosen by an input:
- raising select right after the last data bit, or
- sending one extra clock pulse whose falling edge starts the conversion.

Dropping the enable at any point raises select at once. If this happens in the middle of a read, the read is abandoned and the converter starts over. If the converter stays busy for too many polls in a row, a timeout flag is raised and polling stops.

The serial clock is derived from the system clock by division. Every state change happens on a divider tick, so each serial clock half-period is `HALF_DIV` system cycles.

Top module: `adc_poll_master`

## Requirements
- R1: While reset is applied, and afterwards while `run_en` is low, `sel_n` and `ser_clk` are 1 and `word_vld`, `busy` and `poll_timeout` are 0.
- R2: During a poll, `sel_n` is 0 and `ser_clk` stays 1 with no edge. `ser_din` is sampled one half-period after `sel_n` falls: 1 means busy, 0 means ready.
- R3: After a busy poll, `sel_n` stays high for exactly `POLL_GAP*HALF_DIV` system cycles before the next poll.
- R4: After a ready poll, the clock idles high for one half-period. It then makes 16 low-then-high cycles. `ser_din` is sampled as the clock rises, and the first bit becomes bit 15 of `word_out`. The converter is assumed to change its data line on each falling edge.
- R5: `word_vld` is high for exactly one system cycle per completed read. `word_out` holds its value until the next completed read.
- R6: With `restart_mode` = 0, select rises one half-period after the 16th rising edge. Exactly 16 falling clock edges occur in that select-low window, and `ser_clk` is high when `sel_n` rises.
- R7: With `restart_mode` = 1, one 17th falling edge and its rising edge follow the data bits. Select then rises, giving exactly 17 falling edges in the window. The mode is taken when the 16th bit is sampled.
- R8: `run_en` low forces `sel_n` = 1 and `ser_clk` = 1 on the next clock. A read cut off this way produces no `word_vld`.
- R9: After `POLL_MAX` consecutive busy polls, `poll_timeout` goes to 1, `sel_n` stays high and no further poll starts. Dropping `run_en` clears the flag. A completed read or `run_en` low restarts the count.
- R10: `busy` is 1 from the ready poll until select rises at the end of the read, and 0 during polls and gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Enable; low aborts any activity and clears the timeout flag |
| restart_mode | input | 1 | 0: restart by select rising, 1: restart by an extra clock pulse |
| ser_din | input | 1 | Serial data and readiness from the converter |
| sel_n | output | 1 | Active-low select to the converter |
| ser_clk | output | 1 | Serial clock, idles high |
| word_out | output | W | Last completed result |
| word_vld | output | 1 | One-cycle strobe with a new result |
| busy | output | 1 | Read in progress |
| poll_timeout | output | 1 | Converter never became ready within the poll budget |

## Verification
The bench builds the block with `HALF_DIV` = 2, `POLL_GAP` = 3 and `POLL_MAX` = 6. With these values a busy poll cycle lasts only eight system cycles, so conversion delays of a few dozen cycles produce several busy polls and exact gap measurements within a short run. A converter held busy on purpose reaches the six-poll timeout in about fifty cycles. The divider of two also separates a tick from the data change by a full system cycle, which makes the data-timing checks meaningful.

// File: rtl/pr_pkg.sv
`timescale 1ns/1ps
package pr_pkg;

  // Controller phases; a state change happens only on a divider tick,
  // except the forced return to idle when the enable drops.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_GAP,
    ST_READ,
    ST_EXTRA,
    ST_DONE,
    ST_HALT
  } pr_state_e;

endpackage

// File: rtl/pr_tick_gen.sv
`timescale 1ns/1ps
module pr_tick_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (HALF_DIV <= 1) begin : g_every_cycle
      assign tick = 1'b1;
    end else begin : g_divide
      localparam int unsigned CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = (cnt_q == CNT_LAST);
    end
  endgenerate

endmodule

// File: rtl/pr_rx_shift.sv
`timescale 1ns/1ps
module pr_rx_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         smp_en,
  input  logic         smp_last,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         word_vld
);

  logic [W-1:0] sh_q, sh_d;
  logic [W-1:0] out_q;
  logic         vld_q;
  logic         cap_en;

  assign cap_en = smp_en & smp_last;

  always_comb begin
    sh_d = sh_q;
    if (clr)         sh_d = '0;
    else if (smp_en) sh_d = {sh_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      vld_q <= cap_en;
      if (cap_en) out_q <= {sh_q[W-2:0], din};
    end
  end

  assign word     = out_q;
  assign word_vld = vld_q;

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(word));

endmodule

// File: rtl/adc_poll_master.sv
`timescale 1ns/1ps
module adc_poll_master #(
  parameter int unsigned W        = 16,
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned POLL_GAP = 8,
  parameter int unsigned POLL_MAX = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         restart_mode,
  input  logic         ser_din,
  output logic         sel_n,
  output logic         ser_clk,
  output logic [W-1:0] word_out,
  output logic         word_vld,
  output logic         busy,
  output logic         poll_timeout
);
  import pr_pkg::*;

  localparam int unsigned BCW = (W > 1)        ? $clog2(W)        : 1;
  localparam int unsigned PCW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam int unsigned GCW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam logic [BCW-1:0] BIT_LAST  = BCW'(W - 1);
  localparam logic [PCW-1:0] POLL_LAST = PCW'(POLL_MAX - 1);
  localparam logic [GCW-1:0] GAP_LAST  = GCW'(POLL_GAP - 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  logic tick;

  pr_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(arst_n),
    .tick (tick)
  );

  pr_state_e      st_q, st_d;
  logic           sclk_q, sclk_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic [PCW-1:0] poll_q, poll_d;
  logic [GCW-1:0] gap_q, gap_d;
  logic           err_q, err_d;
  logic           smp_en, smp_last, sh_clr;
  logic           upd_en;

  assign upd_en = tick | ~run_en;

  always_comb begin
    st_d     = st_q;
    sclk_d   = sclk_q;
    bit_d    = bit_q;
    poll_d   = poll_q;
    gap_d    = gap_q;
    err_d    = err_q;
    smp_en   = 1'b0;
    smp_last = 1'b0;
    sh_clr   = 1'b0;
    if (!run_en) begin
      st_d   = ST_IDLE;
      sclk_d = 1'b1;
      err_d  = 1'b0;
      poll_d = '0;
    end else if (tick) begin
      case (st_q)
        ST_IDLE: begin
          st_d   = ST_POLL;
          poll_d = '0;
        end
        ST_POLL: begin
          if (!ser_din) begin
            st_d   = ST_READ;
            bit_d  = '0;
            poll_d = '0;
            sh_clr = 1'b1;
          end else if (poll_q == POLL_LAST) begin
            st_d  = ST_HALT;
            err_d = 1'b1;
          end else begin
            st_d   = ST_GAP;
            gap_d  = '0;
            poll_d = poll_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_LAST) st_d = ST_POLL;
          else                   gap_d = gap_q + 1'b1;
        end
        ST_READ: begin
          if (sclk_q) begin
            sclk_d = 1'b0;
          end else begin
            sclk_d = 1'b1;
            smp_en = 1'b1;
            if (bit_q == BIT_LAST) begin
              smp_last = 1'b1;
              st_d     = restart_mode ? ST_EXTRA : ST_DONE;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end
        end
        ST_EXTRA: begin
          if (sclk_q) begin
            sclk_d = 1'b0;
          end else begin
            sclk_d = 1'b1;
            st_d   = ST_DONE;
          end
        end
        ST_DONE: begin
          st_d  = ST_GAP;
          gap_d = '0;
        end
        ST_HALT: st_d = ST_HALT;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b1;
      bit_q  <= '0;
      poll_q <= '0;
      gap_q  <= '0;
      err_q  <= 1'b0;
    end else if (upd_en) begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      bit_q  <= bit_d;
      poll_q <= poll_d;
      gap_q  <= gap_d;
      err_q  <= err_d;
    end
  end

  pr_rx_shift #(.W(W)) u_shift (
    .clk     (clk),
    .rst_n   (arst_n),
    .clr     (sh_clr),
    .smp_en  (smp_en),
    .smp_last(smp_last),
    .din     (ser_din),
    .word    (word_out),
    .word_vld(word_vld)
  );

  assign sel_n        = !(st_q inside {ST_POLL, ST_READ, ST_EXTRA, ST_DONE});
  assign busy         = st_q inside {ST_READ, ST_EXTRA, ST_DONE};
  assign ser_clk      = sclk_q;
  assign poll_timeout = err_q;

  // R2
  poll_clk_high_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!sel_n && !busy) |-> ser_clk);

  // R5
  vld_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
    word_vld |=> !word_vld);

  // R6
  sel_rise_clk_high_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sel_n) |-> ser_clk);

  // R8
  abort_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !run_en |=> (sel_n && ser_clk && !busy));

  // R9
  timeout_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
    poll_timeout |-> (sel_n && !busy));

endmodule

// File: tb/adc_poll_master_tb.sv
`timescale 1ns/1ps
module adc_poll_master_tb;

  localparam int unsigned HALF_DIV = 2;
  localparam int unsigned POLL_GAP = 3;
  localparam int unsigned POLL_MAX = 6;
  localparam int          NV       = 7;
  localparam int          NLOOP    = 5;
  localparam realtime     GAP_NS   = POLL_GAP * HALF_DIV * 5.0;

  // entry: {data[24:9], restart_mode[8], conversion cycles[7:0]}
  localparam logic [24:0] TBL [0:NV-1] = '{
    {16'hA5C3, 1'b0, 8'd0},
    {16'h0001, 1'b1, 8'd30},
    {16'h8000, 1'b0, 8'd20},
    {16'hFFFF, 1'b1, 8'd5},
    {16'h3C96, 1'b1, 8'd25},
    {16'h7E18, 1'b0, 8'd4},
    {16'h5A0F, 1'b1, 8'd12}
  };

  logic        clk = 1'b0;
  logic        rst_n, run_en, restart_mode, sdo;
  logic        sel_n, ser_clk, word_vld, busy, poll_timeout;
  logic [15:0] word_out;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  adc_poll_master #(
    .W(16), .HALF_DIV(HALF_DIV), .POLL_GAP(POLL_GAP), .POLL_MAX(POLL_MAX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .restart_mode(restart_mode),
    .ser_din(sdo), .sel_n(sel_n), .ser_clk(ser_clk), .word_out(word_out),
    .word_vld(word_vld), .busy(busy), .poll_timeout(poll_timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Converter model, evaluated on falling system clock edges
  int          conv_left = 0;
  int          dev_idx = 0;
  int          fall_cnt = 0;
  int          last_falls = 0;
  int          polls_seen = 0;
  int          vld_seen = 0;
  bit          restarted = 0;
  bit          stuck = 0;
  bit          gap_arm = 0;
  realtime     t_rise = 0;
  logic [15:0] dev_word = TBL[0][24:9];
  logic        cs_prev = 1'b1;
  logic        clk_prev = 1'b1;

  task automatic dev_restart();
    restarted = 1;
    if (dev_idx < NV - 1) dev_idx++;
    dev_word  = TBL[dev_idx][24:9];
    conv_left = int'(TBL[dev_idx][7:0]);
  endtask

  initial sdo = 1'b1;

  always @(negedge clk) begin
    if (conv_left > 0) conv_left--;
    if (sel_n === 1'b0 && cs_prev === 1'b1) begin
      fall_cnt  = 0;
      restarted = 0;
      polls_seen++;
      check(ser_clk === 1'b1, "R2 clock high at poll start", ser_clk, 1);
      if (gap_arm) begin
        check($realtime - t_rise == GAP_NS, "R3 gap length ns",
              int'($realtime - t_rise), int'(GAP_NS));
        gap_arm = 0;
      end
    end
    if (sel_n === 1'b0 && ser_clk === 1'b0 && clk_prev === 1'b1) begin
      fall_cnt++;
      if (fall_cnt == 17) dev_restart();
    end
    if (sel_n === 1'b1 && cs_prev === 1'b0) begin
      last_falls = fall_cnt;
      if (fall_cnt > 0 && !restarted) dev_restart();
      if (fall_cnt == 0) begin
        check(busy === 1'b0, "R10 busy low after busy poll", busy, 0);
        gap_arm = run_en;
        t_rise  = $realtime;
      end
    end
    if (sel_n === 1'b1)              sdo = 1'b1;
    else if (stuck || conv_left > 0) sdo = 1'b1;
    else if (fall_cnt == 0)          sdo = 1'b0;
    else if (fall_cnt <= 16)         sdo = dev_word[16 - fall_cnt];
    else                             sdo = 1'b1;
    if (word_vld === 1'b1) vld_seen++;
    cs_prev  = sel_n;
    clk_prev = ser_clk;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int vb;
    rst_n        = 1'b0;
    run_en       = 1'b0;
    restart_mode = TBL[0][8];
    repeat (4) step();
    // R1 reset state
    check(sel_n === 1'b1,        "R1 sel_n", sel_n, 1);
    check(ser_clk === 1'b1,      "R1 ser_clk", ser_clk, 1);
    check(word_vld === 1'b0,     "R1 word_vld", word_vld, 0);
    check(busy === 1'b0,         "R1 busy", busy, 0);
    check(poll_timeout === 1'b0, "R1 poll_timeout", poll_timeout, 0);
    rst_n = 1'b1;
    repeat (8) step();
    check(sel_n === 1'b1 && polls_seen == 0, "R1 idle while disabled", polls_seen, 0);

    run_en = 1'b1;
    for (int i = 0; i < NLOOP; i++) begin
      while (word_vld !== 1'b1) step();
      check(word_out == TBL[i][24:9], "R4 word MSB first", word_out, TBL[i][24:9]);
      check(busy === 1'b1, "R10 busy during read", busy, 1);
      step();
      check(word_vld === 1'b0, "R5 strobe one cycle", word_vld, 0);
      while (sel_n !== 1'b1) step();
      if (TBL[i][8])
        check(last_falls == 17, "R7 extra falling edge", last_falls, 17);
      else
        check(last_falls == 16, "R6 sixteen falling edges", last_falls, 16);
      check(word_out == TBL[i][24:9], "R5 word held", word_out, TBL[i][24:9]);
      restart_mode = TBL[i + 1][8];
    end

    // R8 abort in the middle of a read
    while (!(sel_n === 1'b0 && fall_cnt == 6)) step();
    vb     = vld_seen;
    run_en = 1'b0;
    gap_arm = 0;
    step();
    step();
    check(sel_n === 1'b1 && ser_clk === 1'b1, "R8 lines released", {sel_n, ser_clk}, 3);
    check(busy === 1'b0, "R8 busy cleared", busy, 0);
    repeat (10) step();
    check(vld_seen == vb, "R8 no strobe for aborted read", vld_seen, vb);
    restart_mode = TBL[6][8];
    run_en       = 1'b1;
    while (word_vld !== 1'b1) step();
    check(word_out == TBL[6][24:9], "R8 fresh conversion read", word_out, TBL[6][24:9]);
    while (sel_n !== 1'b1) step();
    check(last_falls == 17, "R7 extra falling edge after abort", last_falls, 17);

    // R9 timeout with a converter that never finishes
    run_en  = 1'b0;
    gap_arm = 0;
    repeat (3) step();
    stuck      = 1;
    polls_seen = 0;
    run_en     = 1'b1;
    while (poll_timeout !== 1'b1) step();
    gap_arm = 0;
    check(sel_n === 1'b1, "R9 select high on timeout", sel_n, 1);
    repeat (30) step();
    check(polls_seen == POLL_MAX, "R9 poll count", polls_seen, POLL_MAX);
    check(poll_timeout === 1'b1 && sel_n === 1'b1, "R9 stays halted", poll_timeout, 1);
    run_en = 1'b0;
    step();
    step();
    check(poll_timeout === 1'b0, "R9 cleared by enable low", poll_timeout, 0);
    check(busy === 1'b0, "R10 busy low when idle", busy, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule